// File: doc/BRIEF.md
# Oldest-First Issue Queue with Age Vectors

This block is the scheduling core of an out-of-order issue stage. It holds up to `ENTRIES` waiting instructions, each with two source operand tags and a ready flag per source. Entries are never moved once written. A new instruction goes into any free slot. At that moment it records an age vector: one bit per slot, set for every entry that was already in the queue, and therefore older than it.

Each cycle the entries whose two sources are both ready form a request vector. An entry wins a grant port when it requests and no entry marked older in its age vector also requests. Each later port repeats the same test with the earlier winners removed from the request vector. Up to `GRANTS` instructions are therefore picked each cycle, oldest first, and their slots are released at the clock edge. When a slot is released, its column is cleared from every age vector.

Wakeup broadcasts carry result tags and set the matching source ready flags. A flush empties the whole queue in one cycle. Operand payloads, renaming and the execution units sit outside this block; the slot index on each grant port is the handle used to fetch the payload elsewhere.

Top module: `iq_age_issue`

## Requirements
- R1: After reset the queue is empty: no grant port is valid, and every slot is free.
- R2: Each requesting allocation lane receives a free slot, and `alloc_slot` reports it in the same cycle. Requesting lanes take the lowest-numbered free slots, and a lower-numbered lane always gets the lower slot. The entry is occupied from the next cycle.
- R3: `alloc_stall` is high exactly when more lanes request than there are free slots. Slots granted in the current cycle do not count as free. In a stalled cycle no lane is inserted.
- R4: An entry is eligible once both of its sources are ready. A source is ready when its ready flag was set at allocation, or when a wakeup tag equal to its tag arrives, including in the allocation cycle itself. An eligible entry can be granted from the cycle after it becomes ready.
- R5: Grant port 0 carries the oldest eligible entry, port 1 the next oldest, and so on. Valid ports fill from port 0 upward, and no two valid ports carry the same slot.
- R6: A granted entry leaves the queue at the clock edge that ends its grant cycle and is never granted again.
- R7: Age follows insertion order, whatever the slot numbers. An entry inserted in an earlier cycle is older, and within one cycle lane 0 is older than lane 1.
- R8: While `flush` is high no grant port is valid and no lane is inserted. After the edge the queue is empty.
- R9: No more than `GRANTS` entries are granted per cycle. Eligible entries beyond that stay queued in age order for later cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| flush | input | 1 | Empty the queue at the next edge; suppresses grants and inserts |
| alloc_valid | input | ALLOC_W | One request bit per allocation lane |
| alloc_src0_tag | input | ALLOC_W x TAG_W | First source tag per lane |
| alloc_src0_rdy | input | ALLOC_W | First source already available, per lane |
| alloc_src1_tag | input | ALLOC_W x TAG_W | Second source tag per lane |
| alloc_src1_rdy | input | ALLOC_W | Second source already available, per lane |
| wake_valid | input | WAKE_W | One valid bit per wakeup broadcast port |
| wake_tag | input | WAKE_W x TAG_W | Result tag per wakeup port |
| alloc_stall | output | 1 | Not enough free slots; no lane is inserted this cycle |
| alloc_slot | output | ALLOC_W x IDX_W | Slot assigned to each requesting lane |
| grant_valid | output | GRANTS | One valid bit per grant port |
| grant_slot | output | GRANTS x IDX_W | Slot index granted on each port |

## Verification
The hardest case to reach is one where age order and slot order disagree. That case is needed to show that selection follows the age vectors and not slot position. The stimulus fills every slot and drives an extra insert against a full queue to force a stall. It then wakes all entries together, and inserts new instructions into the low-numbered slots the first grants have just freed. A flush then arrives while unready entries are still queued. The remaining checks cover same-cycle wakeup of an allocating lane, a request on the upper lane alone, and a reset with entries in flight.

// File: rtl/iq_age_pkg.sv
`timescale 1ns/1ps
package iq_age_pkg;
   localparam int unsigned IQ_MAX_ENTRIES = 128;
   localparam int unsigned IQ_MAX_GRANTS  = 8;

   function automatic int unsigned iq_idx_bits(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction
endpackage

// File: rtl/iq_slot_alloc.sv
`timescale 1ns/1ps
module iq_slot_alloc #(
   parameter int unsigned ENTRIES = 32,
   parameter int unsigned LANES   = 2,
   parameter int unsigned IDX_W   = 5
) (
   input  logic [ENTRIES-1:0]                free_mask,
   input  logic [LANES-1:0]                  req,
   output logic [LANES-1:0][ENTRIES-1:0]     pick_oh,
   output logic [LANES-1:0][IDX_W-1:0]       pick_idx,
   output logic                              short_o
);
   always_comb begin
      logic [ENTRIES-1:0] avail;
      avail = free_mask;
      for (int a = 0; a < LANES; a++) begin
         pick_oh[a]  = '0;
         pick_idx[a] = '0;
         for (int e = ENTRIES - 1; e >= 0; e--) begin
            if (avail[e]) begin
               pick_oh[a]    = '0;
               pick_oh[a][e] = 1'b1;
               pick_idx[a]   = IDX_W'(e);
            end
         end
         if (req[a]) begin
            avail = avail & ~pick_oh[a];
         end
      end
   end

   assign short_o = ($countones(req) > $countones(free_mask));
endmodule

// File: rtl/iq_entry_state.sv
`timescale 1ns/1ps
module iq_entry_state #(
   parameter int unsigned ENTRIES = 32,
   parameter int unsigned LANES   = 2,
   parameter int unsigned WAKE_W  = 2,
   parameter int unsigned TAG_W   = 8
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              flush,
   input  logic [LANES-1:0]                  ins_en,
   input  logic [LANES-1:0][ENTRIES-1:0]     ins_oh,
   input  logic [LANES-1:0][TAG_W-1:0]       ins_tag0,
   input  logic [LANES-1:0]                  ins_rdy0,
   input  logic [LANES-1:0][TAG_W-1:0]       ins_tag1,
   input  logic [LANES-1:0]                  ins_rdy1,
   input  logic [WAKE_W-1:0]                 wake_valid,
   input  logic [WAKE_W-1:0][TAG_W-1:0]      wake_tag,
   input  logic [ENTRIES-1:0]                release_mask,
   output logic [ENTRIES-1:0]                live,
   output logic [ENTRIES-1:0]                eligible
);
   logic [ENTRIES-1:0]            valid_q, rdy0_q, rdy1_q;
   logic [ENTRIES-1:0][TAG_W-1:0] tag0_q, tag1_q;
   logic [ENTRIES-1:0]            hit0, hit1;
   logic [LANES-1:0]              lhit0, lhit1;

   always_comb begin
      hit0  = '0;
      hit1  = '0;
      lhit0 = '0;
      lhit1 = '0;
      for (int w = 0; w < WAKE_W; w++) begin
         if (wake_valid[w]) begin
            for (int e = 0; e < ENTRIES; e++) begin
               if (wake_tag[w] == tag0_q[e]) hit0[e] = 1'b1;
               if (wake_tag[w] == tag1_q[e]) hit1[e] = 1'b1;
            end
            for (int a = 0; a < LANES; a++) begin
               if (wake_tag[w] == ins_tag0[a]) lhit0[a] = 1'b1;
               if (wake_tag[w] == ins_tag1[a]) lhit1[a] = 1'b1;
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= '0;
         rdy0_q  <= '0;
         rdy1_q  <= '0;
         tag0_q  <= '0;
         tag1_q  <= '0;
      end else if (flush) begin
         valid_q <= '0;
      end else begin
         for (int e = 0; e < ENTRIES; e++) begin
            if (release_mask[e]) valid_q[e] <= 1'b0;
            if (hit0[e])         rdy0_q[e]  <= 1'b1;
            if (hit1[e])         rdy1_q[e]  <= 1'b1;
            for (int a = 0; a < LANES; a++) begin
               if (ins_en[a] && ins_oh[a][e]) begin
                  valid_q[e] <= 1'b1;
                  tag0_q[e]  <= ins_tag0[a];
                  tag1_q[e]  <= ins_tag1[a];
                  rdy0_q[e]  <= ins_rdy0[a] | lhit0[a];
                  rdy1_q[e]  <= ins_rdy1[a] | lhit1[a];
               end
            end
         end
      end
   end

   assign live     = valid_q;
   assign eligible = valid_q & rdy0_q & rdy1_q;
endmodule

// File: rtl/iq_age_matrix.sv
`timescale 1ns/1ps
module iq_age_matrix #(
   parameter int unsigned ENTRIES = 32,
   parameter int unsigned LANES   = 2
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              flush,
   input  logic [ENTRIES-1:0]                live,
   input  logic [ENTRIES-1:0]                release_mask,
   input  logic [LANES-1:0]                  ins_en,
   input  logic [LANES-1:0][ENTRIES-1:0]     ins_oh,
   output logic [ENTRIES-1:0][ENTRIES-1:0]   older
);
   logic [ENTRIES-1:0][ENTRIES-1:0] older_q, older_d;
   logic [LANES-1:0][ENTRIES-1:0]   lane_row;

   // Row stamped into a new entry: survivors plus lower lanes of this cycle.
   always_comb begin
      logic [ENTRIES-1:0] acc;
      acc = live & ~release_mask;
      for (int a = 0; a < LANES; a++) begin
         lane_row[a] = acc;
         if (ins_en[a]) acc = acc | ins_oh[a];
      end
   end

   always_comb begin
      for (int i = 0; i < ENTRIES; i++) begin
         older_d[i] = older_q[i] & ~release_mask;
         for (int a = 0; a < LANES; a++) begin
            if (ins_en[a] && ins_oh[a][i]) older_d[i] = lane_row[a];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         older_q <= '0;
      end else if (flush) begin
         older_q <= '0;
      end else begin
         older_q <= older_d;
      end
   end

   assign older = older_q;
endmodule

// File: rtl/iq_oldest_pick.sv
`timescale 1ns/1ps
module iq_oldest_pick #(
   parameter int unsigned ENTRIES = 32,
   parameter int unsigned GRANTS  = 8,
   parameter int unsigned IDX_W   = 5
) (
   input  logic [ENTRIES-1:0][ENTRIES-1:0]   older,
   input  logic [ENTRIES-1:0]                bid,
   output logic [GRANTS-1:0][ENTRIES-1:0]    win_oh,
   output logic [GRANTS-1:0]                 win_valid,
   output logic [GRANTS-1:0][IDX_W-1:0]      win_idx
);
   for (genvar g = 0; g < GRANTS; g++) begin : g_port
      logic [ENTRIES-1:0] bid_in, win, bid_out;
      if (g == 0) begin : g_head
         assign bid_in = bid;
      end else begin : g_tail
         assign bid_in = g_port[g-1].bid_out;
      end
      for (genvar i = 0; i < ENTRIES; i++) begin : g_row
         assign win[i] = bid_in[i] & ~(|(older[i] & bid_in));
      end
      assign bid_out      = bid_in & ~win;
      assign win_oh[g]    = win;
      assign win_valid[g] = |win;
      always_comb begin
         win_idx[g] = '0;
         for (int i = 0; i < ENTRIES; i++) begin
            if (win[i]) win_idx[g] = win_idx[g] | IDX_W'(i);
         end
      end
   end
endmodule

// File: rtl/iq_age_issue.sv
`timescale 1ns/1ps
module iq_age_issue
   import iq_age_pkg::*;
#(
   parameter int unsigned ENTRIES = 32,
   parameter int unsigned GRANTS  = 8,
   parameter int unsigned ALLOC_W = 2,
   parameter int unsigned WAKE_W  = 2,
   parameter int unsigned TAG_W   = 8,
   localparam int unsigned IDX_W  = iq_idx_bits(ENTRIES)
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              flush,
   input  logic [ALLOC_W-1:0]                alloc_valid,
   input  logic [ALLOC_W-1:0][TAG_W-1:0]     alloc_src0_tag,
   input  logic [ALLOC_W-1:0]                alloc_src0_rdy,
   input  logic [ALLOC_W-1:0][TAG_W-1:0]     alloc_src1_tag,
   input  logic [ALLOC_W-1:0]                alloc_src1_rdy,
   input  logic [WAKE_W-1:0]                 wake_valid,
   input  logic [WAKE_W-1:0][TAG_W-1:0]      wake_tag,
   output logic                              alloc_stall,
   output logic [ALLOC_W-1:0][IDX_W-1:0]     alloc_slot,
   output logic [GRANTS-1:0]                 grant_valid,
   output logic [GRANTS-1:0][IDX_W-1:0]      grant_slot
);
   if (ENTRIES < 2 || ENTRIES > IQ_MAX_ENTRIES) begin : g_bad_entries
      $error("iq_age_issue: ENTRIES out of range");
   end
   if (GRANTS < 1 || GRANTS > IQ_MAX_GRANTS || GRANTS > ENTRIES) begin : g_bad_grants
      $error("iq_age_issue: GRANTS out of range");
   end
   if (ALLOC_W < 1 || ALLOC_W > ENTRIES) begin : g_bad_alloc
      $error("iq_age_issue: ALLOC_W out of range");
   end
   if (WAKE_W < 1 || TAG_W < 1) begin : g_bad_wake
      $error("iq_age_issue: WAKE_W and TAG_W must be nonzero");
   end

   logic [ENTRIES-1:0]              live, eligible, release_mask;
   logic [ALLOC_W-1:0][ENTRIES-1:0] pick_oh;
   logic [ALLOC_W-1:0]              ins_en;
   logic                            short_w;
   logic [ENTRIES-1:0][ENTRIES-1:0] older;
   logic [GRANTS-1:0][ENTRIES-1:0]  win_oh;
   logic [GRANTS-1:0]               win_valid;

   iq_slot_alloc #(.ENTRIES(ENTRIES), .LANES(ALLOC_W), .IDX_W(IDX_W)) u_alloc (
      .free_mask (~live),
      .req       (alloc_valid),
      .pick_oh   (pick_oh),
      .pick_idx  (alloc_slot),
      .short_o   (short_w)
   );

   assign alloc_stall = short_w;
   assign ins_en      = alloc_valid & {ALLOC_W{~short_w & ~flush}};

   iq_entry_state #(.ENTRIES(ENTRIES), .LANES(ALLOC_W), .WAKE_W(WAKE_W), .TAG_W(TAG_W)) u_state (
      .clk          (clk),
      .rst_n        (rst_n),
      .flush        (flush),
      .ins_en       (ins_en),
      .ins_oh       (pick_oh),
      .ins_tag0     (alloc_src0_tag),
      .ins_rdy0     (alloc_src0_rdy),
      .ins_tag1     (alloc_src1_tag),
      .ins_rdy1     (alloc_src1_rdy),
      .wake_valid   (wake_valid),
      .wake_tag     (wake_tag),
      .release_mask (release_mask),
      .live         (live),
      .eligible     (eligible)
   );

   iq_age_matrix #(.ENTRIES(ENTRIES), .LANES(ALLOC_W)) u_age (
      .clk          (clk),
      .rst_n        (rst_n),
      .flush        (flush),
      .live         (live),
      .release_mask (release_mask),
      .ins_en       (ins_en),
      .ins_oh       (pick_oh),
      .older        (older)
   );

   iq_oldest_pick #(.ENTRIES(ENTRIES), .GRANTS(GRANTS), .IDX_W(IDX_W)) u_pick (
      .older     (older),
      .bid       (eligible),
      .win_oh    (win_oh),
      .win_valid (win_valid),
      .win_idx   (grant_slot)
   );

   always_comb begin
      release_mask = '0;
      for (int g = 0; g < GRANTS; g++) release_mask = release_mask | win_oh[g];
   end

   assign grant_valid = flush ? '0 : win_valid;
endmodule

// File: rtl/iq_age_issue_chk.sv
`timescale 1ns/1ps
module iq_age_issue_chk
   import iq_age_pkg::*;
#(
   parameter int unsigned ENTRIES = 32,
   parameter int unsigned GRANTS  = 8,
   parameter int unsigned ALLOC_W = 2,
   parameter int unsigned WAKE_W  = 2,
   parameter int unsigned TAG_W   = 8,
   localparam int unsigned IDX_W  = iq_idx_bits(ENTRIES)
) (
   input logic                          clk,
   input logic                          rst_n,
   input logic                          flush,
   input logic [ALLOC_W-1:0]            alloc_valid,
   input logic                          alloc_stall,
   input logic [ALLOC_W-1:0][IDX_W-1:0] alloc_slot,
   input logic [GRANTS-1:0]             grant_valid,
   input logic [GRANTS-1:0][IDX_W-1:0]  grant_slot
);
   for (genvar g = 1; g < GRANTS; g++) begin : g_contig
      // R5
      grant_contig_chk: assert property (@(posedge clk) disable iff (!rst_n)
         grant_valid[g] |-> grant_valid[g-1]);
   end

   for (genvar g = 0; g < GRANTS; g++) begin : g_pair_g
      for (genvar h = 0; h < GRANTS; h++) begin : g_pair_h
         if (h > g) begin : g_distinct
            // R5
            grant_distinct_chk: assert property (@(posedge clk) disable iff (!rst_n)
               (grant_valid[g] && grant_valid[h]) |-> (grant_slot[g] != grant_slot[h]));
         end
         // R6
         no_regrant_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (grant_valid[g] && !flush) |=>
               !(grant_valid[h] && (grant_slot[h] == $past(grant_slot[g]))));
      end
   end

   for (genvar a = 0; a < ALLOC_W; a++) begin : g_lane_a
      for (genvar b = a + 1; b < ALLOC_W; b++) begin : g_lane_b
         // R2
         lane_slot_distinct_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (alloc_valid[a] && alloc_valid[b] && !alloc_stall) |->
               (alloc_slot[a] != alloc_slot[b]));
      end
   end

   // R8
   flush_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush |-> (grant_valid == '0));

   // R8
   flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (grant_valid == '0));
endmodule

bind iq_age_issue iq_age_issue_chk #(
   .ENTRIES(ENTRIES), .GRANTS(GRANTS), .ALLOC_W(ALLOC_W),
   .WAKE_W(WAKE_W), .TAG_W(TAG_W)
) u_chk (.*);

// File: tb/iq_age_issue_bench.sv
`timescale 1ns/1ps
module iq_age_issue_bench;
   localparam int E = 8;
   localparam int G = 2;
   localparam int A = 2;
   localparam int W = 1;
   localparam int T = 6;
   localparam int X = 3;

   typedef struct packed {
      logic [1:0]      av;
      logic [1:0]      r0;
      logic [1:0]      r1;
      logic [1:0][5:0] t0;
      logic [1:0][5:0] t1;
      logic            wv;
      logic [5:0]      wt;
      logic            fl;
   } row_t;

   localparam int NROWS = 24;
   localparam row_t TBL [NROWS] = '{
      '{2'b11, 2'b11, 2'b11, {6'd1, 6'd2},  {6'd3, 6'd4}, 1'b0, 6'd0,  1'b0}, // 0 two ready inserts
      '{2'b11, 2'b00, 2'b11, {6'd6, 6'd5},  {6'd3, 6'd4}, 1'b0, 6'd0,  1'b0}, // 1 waiting on 5 and 6
      '{2'b11, 2'b11, 2'b11, {6'd1, 6'd2},  {6'd3, 6'd4}, 1'b0, 6'd0,  1'b0}, // 2 younger into freed low slots
      '{2'b00, 2'b00, 2'b00, {6'd0, 6'd0},  {6'd0, 6'd0}, 1'b1, 6'd5,  1'b0}, // 3 wake 5
      '{2'b00, 2'b00, 2'b00, {6'd0, 6'd0},  {6'd0, 6'd0}, 1'b1, 6'd6,  1'b0}, // 4 wake 6
      '{2'b00, 2'b00, 2'b00, {6'd0, 6'd0},  {6'd0, 6'd0}, 1'b0, 6'd0,  1'b0}, // 5
      '{2'b11, 2'b00, 2'b11, {6'd9, 6'd9},  {6'd1, 6'd1}, 1'b0, 6'd0,  1'b0}, // 6 fill with waiters
      '{2'b11, 2'b00, 2'b11, {6'd9, 6'd9},  {6'd1, 6'd1}, 1'b0, 6'd0,  1'b0}, // 7
      '{2'b11, 2'b00, 2'b11, {6'd9, 6'd9},  {6'd1, 6'd1}, 1'b0, 6'd0,  1'b0}, // 8
      '{2'b11, 2'b00, 2'b11, {6'd9, 6'd9},  {6'd1, 6'd1}, 1'b0, 6'd0,  1'b0}, // 9 queue full after
      '{2'b11, 2'b00, 2'b11, {6'd9, 6'd9},  {6'd1, 6'd1}, 1'b0, 6'd0,  1'b0}, // 10 stall
      '{2'b01, 2'b01, 2'b00, {6'd0, 6'd0},  {6'd0, 6'd12},1'b1, 6'd9,  1'b0}, // 11 stall, wake all
      '{2'b01, 2'b11, 2'b11, {6'd0, 6'd0},  {6'd0, 6'd0}, 1'b0, 6'd0,  1'b0}, // 12 eight eligible
      '{2'b11, 2'b11, 2'b11, {6'd0, 6'd0},  {6'd0, 6'd0}, 1'b1, 6'd12, 1'b0}, // 13 young into slots 0,1
      '{2'b10, 2'b11, 2'b11, {6'd0, 6'd0},  {6'd0, 6'd0}, 1'b0, 6'd0,  1'b0}, // 14 upper lane only
      '{2'b00, 2'b00, 2'b00, {6'd0, 6'd0},  {6'd0, 6'd0}, 1'b0, 6'd0,  1'b0}, // 15 age beats index
      '{2'b11, 2'b00, 2'b00, {6'd40,6'd40}, {6'd41,6'd41},1'b0, 6'd0,  1'b0}, // 16 waiters before flush
      '{2'b11, 2'b11, 2'b11, {6'd0, 6'd0},  {6'd0, 6'd0}, 1'b0, 6'd0,  1'b1}, // 17 flush drops inserts
      '{2'b11, 2'b11, 2'b11, {6'd0, 6'd0},  {6'd0, 6'd0}, 1'b1, 6'd40, 1'b0}, // 18 after flush
      '{2'b11, 2'b10, 2'b11, {6'd0, 6'd20}, {6'd0, 6'd0}, 1'b1, 6'd20, 1'b0}, // 19 same-cycle wake
      '{2'b00, 2'b00, 2'b00, {6'd0, 6'd0},  {6'd0, 6'd0}, 1'b0, 6'd0,  1'b0}, // 20
      '{2'b00, 2'b00, 2'b00, {6'd0, 6'd0},  {6'd0, 6'd0}, 1'b0, 6'd0,  1'b0}, // 21
      '{2'b00, 2'b00, 2'b00, {6'd0, 6'd0},  {6'd0, 6'd0}, 1'b0, 6'd0,  1'b0}, // 22
      '{2'b00, 2'b00, 2'b00, {6'd0, 6'd0},  {6'd0, 6'd0}, 1'b0, 6'd0,  1'b0}  // 23
   };

   logic                clk = 1'b0;
   logic                rst_n = 1'b0;
   logic                flush = 1'b0;
   logic [A-1:0]        alloc_valid = '0;
   logic [A-1:0][T-1:0] alloc_src0_tag = '0;
   logic [A-1:0]        alloc_src0_rdy = '0;
   logic [A-1:0][T-1:0] alloc_src1_tag = '0;
   logic [A-1:0]        alloc_src1_rdy = '0;
   logic [W-1:0]        wake_valid = '0;
   logic [W-1:0][T-1:0] wake_tag = '0;
   logic                alloc_stall;
   logic [A-1:0][X-1:0] alloc_slot;
   logic [G-1:0]        grant_valid;
   logic [G-1:0][X-1:0] grant_slot;

   always #2 clk = ~clk;

   iq_age_issue #(.ENTRIES(E), .GRANTS(G), .ALLOC_W(A), .WAKE_W(W), .TAG_W(T)) u_iq_age_issue (
      .clk(clk), .rst_n(rst_n), .flush(flush),
      .alloc_valid(alloc_valid),
      .alloc_src0_tag(alloc_src0_tag), .alloc_src0_rdy(alloc_src0_rdy),
      .alloc_src1_tag(alloc_src1_tag), .alloc_src1_rdy(alloc_src1_rdy),
      .wake_valid(wake_valid), .wake_tag(wake_tag),
      .alloc_stall(alloc_stall), .alloc_slot(alloc_slot),
      .grant_valid(grant_valid), .grant_slot(grant_slot)
   );

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   bit         m_valid [E];
   int         m_seq   [E];
   bit         m_r0    [E];
   bit         m_r1    [E];
   logic [5:0] m_t0    [E];
   logic [5:0] m_t1    [E];
   int         seq_ctr = 0;

   task automatic check(input string req, input string what, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic model_reset();
      for (int e = 0; e < E; e++) begin
         m_valid[e] = 1'b0; m_r0[e] = 1'b0; m_r1[e] = 1'b0; m_seq[e] = 0;
         m_t0[e] = '0; m_t1[e] = '0;
      end
   endtask

   task automatic run_cycle(input row_t r);
      bit taken [E];
      bit used  [E];
      int eg [G];
      bit egv [G];
      int es [A];
      int nfree, nreq, nelig, ngnt, best;
      bit estall;
      @(negedge clk);
      alloc_valid    = r.av;
      alloc_src0_rdy = r.r0;
      alloc_src1_rdy = r.r1;
      alloc_src0_tag = r.t0;
      alloc_src1_tag = r.t1;
      wake_valid[0]  = r.wv;
      wake_tag[0]    = r.wt;
      flush          = r.fl;
      #1;
      nelig = 0;
      for (int e = 0; e < E; e++) begin
         taken[e] = 1'b0; used[e] = 1'b0;
         if (m_valid[e] && m_r0[e] && m_r1[e]) nelig++;
      end
      ngnt = 0;
      for (int g = 0; g < G; g++) begin
         best = -1;
         egv[g] = 1'b0; eg[g] = 0;
         for (int e = 0; e < E; e++)
            if (m_valid[e] && m_r0[e] && m_r1[e] && !taken[e] &&
                (best < 0 || m_seq[e] < m_seq[best])) best = e;
         if (!r.fl && best >= 0) begin
            egv[g] = 1'b1; eg[g] = best; taken[best] = 1'b1;
         end
         check("R4", $sformatf("grant_valid[%0d]", g), int'(grant_valid[g]), int'(egv[g]));
         if (egv[g] && grant_valid[g])
            check("R5 R7", $sformatf("grant_slot[%0d]", g), int'(grant_slot[g]), eg[g]);
         if (grant_valid[g]) ngnt++;
      end
      if (!r.fl) check("R9", "grant count", ngnt, (nelig < G) ? nelig : G);
      nfree = 0; nreq = 0;
      for (int e = 0; e < E; e++) if (!m_valid[e]) nfree++;
      for (int a = 0; a < A; a++) if (r.av[a]) nreq++;
      estall = (nreq > nfree);
      check("R3", "alloc_stall", int'(alloc_stall), int'(estall));
      for (int a = 0; a < A; a++) begin
         es[a] = -1;
         if (r.av[a] && !estall) begin
            for (int e = 0; e < E; e++)
               if (es[a] < 0 && !m_valid[e] && !used[e]) es[a] = e;
            used[es[a]] = 1'b1;
            check("R2", $sformatf("alloc_slot[%0d]", a), int'(alloc_slot[a]), es[a]);
         end
      end
      if (r.fl) begin
         model_reset();
      end else begin
         for (int g = 0; g < G; g++) if (egv[g]) m_valid[eg[g]] = 1'b0;
         for (int e = 0; e < E; e++) begin
            if (r.wv && r.wt == m_t0[e]) m_r0[e] = 1'b1;
            if (r.wv && r.wt == m_t1[e]) m_r1[e] = 1'b1;
         end
         if (!estall) begin
            for (int a = 0; a < A; a++) begin
               if (r.av[a]) begin
                  m_valid[es[a]] = 1'b1;
                  m_seq[es[a]]   = seq_ctr;
                  seq_ctr++;
                  m_t0[es[a]] = r.t0[a];
                  m_t1[es[a]] = r.t1[a];
                  m_r0[es[a]] = r.r0[a] | (r.wv && r.wt == r.t0[a]);
                  m_r1[es[a]] = r.r1[a] | (r.wv && r.wt == r.t1[a]);
               end
            end
         end
      end
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         n_cmp++;
         $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
         summary();
         $finish;
      end
   end

   initial begin
      model_reset();
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1: empty after reset, both lanes see slots 0 and 1
      check("R1", "grant_valid after reset", int'(grant_valid), 0);
      alloc_valid = 2'b11;
      #1;
      check("R1", "alloc_stall after reset", int'(alloc_stall), 0);
      check("R1", "alloc_slot[1] after reset", int'(alloc_slot[1]), 1);
      alloc_valid = 2'b00;

      for (int i = 0; i < NROWS; i++) run_cycle(TBL[i]);

      // R1: reset with entries in flight clears them
      run_cycle('{2'b11, 2'b11, 2'b11, {6'd0, 6'd0}, {6'd0, 6'd0}, 1'b0, 6'd0, 1'b0});
      @(negedge clk);
      alloc_valid = 2'b00;
      wake_valid  = '0;
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      model_reset();
      #1;
      check("R1", "grant_valid after mid-run reset", int'(grant_valid), 0);
      run_cycle('{2'b00, 2'b00, 2'b00, {6'd0, 6'd0}, {6'd0, 6'd0}, 1'b0, 6'd0, 1'b0});
      // R6 R8: a ready pair granted once, then gone
      run_cycle('{2'b11, 2'b11, 2'b11, {6'd0, 6'd0}, {6'd0, 6'd0}, 1'b0, 6'd0, 1'b0});
      run_cycle('{2'b00, 2'b00, 2'b00, {6'd0, 6'd0}, {6'd0, 6'd0}, 1'b0, 6'd0, 1'b0});
      run_cycle('{2'b00, 2'b00, 2'b00, {6'd0, 6'd0}, {6'd0, 6'd0}, 1'b0, 6'd0, 1'b0});
      check("R6", "no regrant", int'(grant_valid), 0);

      done = 1'b1;
      summary();
      $finish;
   end
endmodule